// File: doc/BRIEF.md
# Multi-Lane SPI Master

This block is an SPI master with one chip select, one serial clock and several parallel data lanes, four by default. Each lane has its own transmit shifter and receive shifter, and every lane shifts on the same clock edges. One transmit FIFO feeds the lanes and one receive FIFO collects their results. Software, or a sequencer upstream, loads words into the transmit FIFO and then issues a command. The command gives a word count, a word width and a lane mode.

The lane mode decides how the single word stream maps onto the lanes. In single mode only lane 0 carries data. This is the ordinary case, used for a device with one data line in each direction. In mirror mode every lane sends the same word. Only the lane 0 receive word is stored, and the other lanes are compared against it. In stripe mode consecutive words are dealt round-robin across all lanes. This lets one command read a simultaneous-sampling converter whose channels each come back on their own line. Chip select stays asserted across all words of a command. The transfer pauses between words whenever the receive FIFO lacks room or the transmit FIFO lacks data.

Top module: `mlspi_ctrl`

## Requirements
- R1: A command is taken when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while no command is active. Width codes are 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Mode codes are 0 for single, 1 for mirror and 2 for stripe.
- R2: A command is rejected if its count is zero, its width code is 3, its mode code is 3, or it is a stripe command whose count is not a multiple of the lane count. A rejected command raises `cmd_err` for exactly one cycle, causes no chip-select, clock or FIFO activity, and leaves `cmd_ready` high.
- R3: Chip select falls exactly HALF clock cycles before the first rising SCLK edge of a command. It stays low across every word of that command. It rises no sooner than HALF cycles after the last falling edge.
- R4: SCLK is low whenever chip select is high. Within a word, SCLK stays high for HALF cycles and low for HALF cycles between its rising edges. Data is shifted MSB first: MOSI changes only on falling edges and MISO is sampled on rising edges.
- R5: In single mode, lane 0 carries word k of the stream, MOSI on every other lane stays 0, and MISO on the other lanes has no effect on the received data.
- R6: In mirror mode, every lane sends the same word, and only the lane 0 receive word is written to the receive FIFO, once per word.
- R7: `mirror_mismatch` is set when, in mirror mode, any lane's received word differs from lane 0's. It holds until the next accepted command, which clears it.
- R8: In stripe mode, word k goes to lane k mod LANES. After each group of LANES words, the received lane words are pushed into the receive FIFO in lane order 0, 1, 2, 3.
- R9: When the receive FIFO cannot take a word group, or the transmit FIFO cannot supply one, the block waits between words with SCLK low and chip select held. No data is lost or duplicated when it resumes.
- R10: Each received word sits in the low bits of `rx_data`, and every bit above the word width is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle, ready to take a command |
| cmd_count | input | CNT_W | Total number of words in the command |
| cmd_width | input | 2 | Word width code (0: 8, 1: 16, 2: 32) |
| cmd_mode | input | 2 | Lane mode (0: single, 1: mirror, 2: stripe) |
| cmd_err | output | 1 | One-cycle pulse when a command is rejected |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit FIFO has space |
| tx_data | input | 32 | Transmit word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 32 | Received word, zero-extended |
| mirror_mismatch | output | 1 | Mirror-mode lane disagreement flag |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | LANES | Serial output, one bit per lane |
| spi_miso | input | LANES | Serial input, one bit per lane |

## Verification
The assertions assume a well-behaved upstream. Words are pushed only through the ready handshake, received words are popped only while `rx_valid` is high, and LANES does not exceed the FIFO depth. The MISO lines only need to be stable at the internal sampling edge. The bench therefore drives every input half a cycle away from the active edge. It changes MISO only after it has seen a falling SCLK. It offers transmit and receive handshakes only when the ready or valid signal allows them. It drops `cmd_valid` one cycle after acceptance, so a bad command raises exactly one error pulse.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

    typedef enum logic [1:0] {
        LM_SINGLE = 2'd0,
        LM_MIRROR = 2'd1,
        LM_STRIPE = 2'd2
    } lane_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_SHIFT,
        ST_PUSH,
        ST_TRAIL
    } ctl_state_e;

    // width code 0/1/2 -> 8/16/32 bits
    function automatic logic [5:0] word_bits(input logic [1:0] wc);
        return 6'd8 << wc;
    endfunction

endpackage

// File: rtl/mlspi_fifo.sv
module mlspi_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        wp_d  = push ? wp_q + AW'(1) : wp_q;
        rp_d  = pop  ? rp_q + AW'(1) : rp_q;
        cnt_d = cnt_q;
        if (push && !pop) cnt_d = cnt_q + CW'(1);
        if (pop && !push) cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp_q] <= wdata;
    end

    assign rdata = mem[rp_q];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/mlspi_lane.sv
module mlspi_lane
    import mlspi_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic [1:0]    wcode,
    input  logic          shift_en,
    input  logic          sample_en,
    input  logic          sdi,
    output logic          sdo,
    output logic [DW-1:0] rx_word
);

    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } lane_t;

    lane_t d, q;
    logic [6:0] pad;

    // left-align the word so its MSB sits at the shifter output
    assign pad = 7'(DW) - {1'b0, word_bits(wcode)};

    always_comb begin
        d = q;
        if (load) begin
            d.tx = load_word << pad;
            d.rx = '0;
        end else begin
            if (shift_en)  d.tx = {q.tx[DW-2:0], 1'b0};
            if (sample_en) d.rx = {q.rx[DW-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo     = q.tx[DW-1];
    assign rx_word = q.rx;

endmodule

// File: rtl/mlspi_ctrl.sv
module mlspi_ctrl
    import mlspi_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int HALF       = 2,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [1:0]       cmd_width,
    input  logic [1:0]       cmd_mode,
    output logic             cmd_err,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [31:0]      tx_data,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic [31:0]      rx_data,
    output logic             mirror_mismatch,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic [LANES-1:0] spi_mosi,
    input  logic [LANES-1:0] spi_miso
);

    localparam int DW     = 32;
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int TICK_W = $clog2(HALF) + 1;
    localparam int FC_W   = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        ctl_state_e       st;
        lane_mode_e       mode;
        logic [1:0]       wc;
        logic [CNT_W-1:0] remain;
        logic [LIDX_W-1:0] idx;
        logic [TICK_W-1:0] tick;
        logic [5:0]       bitn;
        logic             cs_n;
        logic             sclk;
        logic             mism;
        logic             err;
    } ctl_t;

    ctl_t d, q;

    logic          tx_pop, tx_full, tx_empty, rx_push, rx_full, rx_empty;
    logic [DW-1:0] tx_head, rx_wdata;
    logic [FC_W-1:0] tx_cnt, rx_cnt, rx_free, need;
    logic [CNT_W-1:0] cnt_need;
    logic [LIDX_W-1:0] last_idx;
    logic          room_ok, cmd_bad, lanes_differ, ld_en, shift_en, sample_en;
    logic [5:0]    bits;
    logic [DW-1:0] lane_rx [LANES];

    mlspi_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .push(tx_valid && tx_ready), .wdata(tx_data),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    mlspi_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_valid && rx_ready), .rdata(rx_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;

    always_comb begin
        need     = (q.mode == LM_STRIPE) ? FC_W'(LANES) : FC_W'(1);
        cnt_need = (q.mode == LM_STRIPE) ? CNT_W'(LANES) : CNT_W'(1);
        last_idx = (q.mode == LM_STRIPE) ? LIDX_W'(LANES - 1) : '0;
        rx_free  = FC_W'(FIFO_DEPTH) - rx_cnt;
        room_ok  = (tx_cnt >= need) && (rx_free >= need);
        bits     = word_bits(q.wc);
        cmd_bad  = (cmd_count == '0) || (cmd_width == 2'd3) || (cmd_mode == 2'd3) ||
                   ((cmd_mode == LM_STRIPE) && ((cmd_count % CNT_W'(LANES)) != '0));
        lanes_differ = 1'b0;
        for (int g = 1; g < LANES; g++)
            if (lane_rx[g] != lane_rx[0]) lanes_differ = 1'b1;
    end

    always_comb begin
        d         = q;
        d.err     = 1'b0;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        rx_wdata  = lane_rx[0];
        ld_en     = 1'b0;
        shift_en  = 1'b0;
        sample_en = 1'b0;
        unique case (q.st)
            ST_IDLE: if (cmd_valid) begin
                if (cmd_bad) d.err = 1'b1;
                else begin
                    d.mode   = lane_mode_e'(cmd_mode);
                    d.wc     = cmd_width;
                    d.remain = cmd_count;
                    d.idx    = '0;
                    d.mism   = 1'b0;
                    d.st     = ST_LOAD;
                end
            end
            ST_LOAD: if (q.idx != '0 || room_ok) begin
                tx_pop = 1'b1;
                ld_en  = 1'b1;
                if (q.idx == last_idx) begin
                    d.idx  = '0;
                    d.tick = '0;
                    d.bitn = '0;
                    d.cs_n = 1'b0;
                    d.st   = ST_LEAD;
                end else d.idx = q.idx + LIDX_W'(1);
            end
            ST_LEAD: if (q.tick == TICK_W'(HALF - 1)) begin
                d.tick    = '0;
                d.sclk    = 1'b1;
                sample_en = 1'b1;
                d.st      = ST_SHIFT;
            end else d.tick = q.tick + TICK_W'(1);
            ST_SHIFT: if (q.tick == TICK_W'(HALF - 1)) begin
                d.tick = '0;
                if (!q.sclk) begin
                    d.sclk    = 1'b1;
                    sample_en = 1'b1;
                end else begin
                    d.sclk = 1'b0;
                    if (q.bitn == bits - 6'd1) begin
                        d.idx = '0;
                        d.st  = ST_PUSH;
                    end else begin
                        d.bitn   = q.bitn + 6'd1;
                        shift_en = 1'b1;
                    end
                end
            end else d.tick = q.tick + TICK_W'(1);
            ST_PUSH: begin
                rx_push  = 1'b1;
                rx_wdata = (q.mode == LM_STRIPE) ? lane_rx[q.idx] : lane_rx[0];
                if (q.mode == LM_MIRROR && lanes_differ) d.mism = 1'b1;
                if (q.idx == last_idx) begin
                    d.idx    = '0;
                    d.tick   = '0;
                    d.remain = q.remain - cnt_need;
                    d.st     = (q.remain == cnt_need) ? ST_TRAIL : ST_LOAD;
                end else d.idx = q.idx + LIDX_W'(1);
            end
            ST_TRAIL: if (q.tick == TICK_W'(HALF - 1)) begin
                d.tick = '0;
                d.cs_n = 1'b1;
                d.st   = ST_IDLE;
            end else d.tick = q.tick + TICK_W'(1);
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.mode <= LM_SINGLE;
            q.cs_n <= 1'b1;
        end else q <= d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic          ld_g;
        logic [DW-1:0] word_g;
        assign ld_g   = ld_en && ((q.mode != LM_STRIPE) || (q.idx == LIDX_W'(g)));
        assign word_g = (q.mode == LM_SINGLE && g != 0) ? '0 : tx_head;
        mlspi_lane #(.DW(DW)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(ld_g), .load_word(word_g), .wcode(q.wc),
            .shift_en(shift_en), .sample_en(sample_en), .sdi(spi_miso[g]),
            .sdo(spi_mosi[g]), .rx_word(lane_rx[g]));
    end

    assign cmd_ready       = (q.st == ST_IDLE);
    assign cmd_err         = q.err;
    assign mirror_mismatch = q.mism;
    assign spi_cs_n        = q.cs_n;
    assign spi_sclk        = q.sclk;

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R4
    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (spi_cs_n && cmd_ready)); // R2
    AST_SINGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == LM_SINGLE && !spi_cs_n) |-> (spi_mosi >> 1) == '0); // R5
    AST_MIRROR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == LM_MIRROR && !spi_cs_n) |->
            ($countones(spi_mosi) == 0 || $countones(spi_mosi) == LANES)); // R6
    AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R9
    AST_TX_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R9

endmodule

// File: tb/mlspi_ctrl_bench.sv
module mlspi_ctrl_bench;

    localparam int LANES = 4;
    localparam int HALF  = 2;
    localparam int CNT_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, cmd_err;
    logic [CNT_W-1:0] cmd_count = '0;
    logic [1:0] cmd_width = '0, cmd_mode = '0;
    logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0, mirror_mismatch;
    logic [31:0] tx_data = '0, rx_data;
    logic spi_cs_n, spi_sclk;
    logic [LANES-1:0] spi_mosi, spi_miso;

    mlspi_ctrl #(.LANES(LANES), .FIFO_DEPTH(8), .HALF(HALF), .CNT_W(CNT_W)) u_mlspi_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_count(cmd_count), .cmd_width(cmd_width), .cmd_mode(cmd_mode), .cmd_err(cmd_err),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .mirror_mismatch(mirror_mismatch), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    always #5 clk = ~clk;

    int total = 0, bad = 0, wbits = 8;
    bit rx_en = 1'b1, finished = 1'b0;
    string cur_req = "R5";
    logic [127:0] mosi_q[$], miso_q[$];
    logic [31:0]  rx_q[$], txq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask();
        return (wbits == 32) ? 32'hFFFF_FFFF : ((32'd1 << wbits) - 32'd1);
    endfunction

    // transmit feeder
    initial begin
        forever begin
            @(negedge clk);
            tx_valid = 1'b0;
            if (rst_n && txq.size() > 0 && tx_ready) begin
                tx_valid = 1'b1;
                tx_data  = txq.pop_front();
            end
        end
    end

    // receive consumer: compares every popped word with the model
    initial begin
        forever begin
            @(negedge clk);
            rx_ready = 1'b0;
            if (rst_n && rx_en && rx_valid) begin
                rx_ready = 1'b1;
                if (rx_q.size() == 0) chk(1'b0, cur_req, "unexpected rx word", rx_data, 0);
                else begin
                    logic [31:0] e;
                    e = rx_q.pop_front();
                    chk(rx_data == e, cur_req, "rx word", rx_data, e);
                    chk((rx_data & ~wmask()) == 0, "R10", "rx upper bits", rx_data, e); // R10
                end
            end
        end
    end

    // serial device model and bus timing monitor, evaluated every clock
    initial begin
        logic pcs, psc, first, rise, fall;
        int since, hi, lo, bitc;
        logic [127:0] cur;
        logic [31:0] cap [LANES];
        pcs = 1'b1; psc = 1'b0; first = 1'b0; since = 0; hi = 0; lo = 0; bitc = 0; cur = '0;
        spi_miso = '0;
        for (int l = 0; l < LANES; l++) cap[l] = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                rise = spi_sclk && !psc;
                fall = !spi_sclk && psc;
                chk(!(spi_cs_n && spi_sclk), "R4", "sclk high while deselected", spi_sclk, 0);
                if (pcs && !spi_cs_n) begin
                    first = 1'b1; bitc = 0;
                    if (miso_q.size() > 0) cur = miso_q.pop_front();
                    for (int l = 0; l < LANES; l++) spi_miso[l] = cur[l*32 + wbits - 1];
                end
                if (!pcs && spi_cs_n) chk(lo >= HALF, "R3", "cs rise after last edge", lo, HALF);
                if (rise) begin
                    if (first) chk(since == HALF, "R3", "cs lead time", since, HALF);
                    else if (bitc != 0) chk(lo == HALF, "R4", "sclk low phase", lo, HALF);
                    first = 1'b0;
                    for (int l = 0; l < LANES; l++) cap[l] = {cap[l][30:0], spi_mosi[l]};
                    bitc++;
                    if (bitc == wbits) begin
                        bitc = 0;
                        if (mosi_q.size() == 0) chk(1'b0, cur_req, "unexpected mosi word", 0, 0);
                        else begin
                            logic [127:0] m;
                            m = mosi_q.pop_front();
                            for (int l = 0; l < LANES; l++)
                                chk((cap[l] & wmask()) == m[l*32 +: 32], cur_req, "mosi lane word",
                                    cap[l] & wmask(), m[l*32 +: 32]);
                        end
                    end
                end
                if (fall) begin
                    chk(hi == HALF, "R4", "sclk high phase", hi, HALF);
                    if (bitc == 0) begin
                        if (miso_q.size() > 0) begin
                            cur = miso_q.pop_front();
                            for (int l = 0; l < LANES; l++) spi_miso[l] = cur[l*32 + wbits - 1];
                        end
                    end else
                        for (int l = 0; l < LANES; l++) spi_miso[l] = cur[l*32 + wbits - 1 - bitc];
                end
                if (pcs && !spi_cs_n) since = 1; else since++;
                hi = spi_sclk ? (rise ? 1 : hi + 1) : 0;
                lo = !spi_sclk ? (fall ? 1 : lo + 1) : 0;
                pcs = spi_cs_n; psc = spi_sclk;
            end
        end
    end

    task automatic issue(input int mode, input int wc, input int cnt, output logic err);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_mode = 2'(mode); cmd_width = 2'(wc); cmd_count = CNT_W'(cnt);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        err = cmd_err;
        cmd_valid = 1'b0;
    endtask

    task automatic run_cmd(input int mode, input int wc, input int cnt, input int bad_lane,
                           input bit hold);
        logic [31:0] w [64];
        logic [127:0] m, r;
        logic err;
        int beats;
        wbits = 8 << wc;
        cur_req = (mode == 0) ? "R5" : (mode == 1) ? "R6" : "R8";
        beats = (mode == 2) ? cnt / LANES : cnt;
        for (int k = 0; k < cnt; k++) begin
            w[k] = $urandom() & wmask();
            txq.push_back(w[k]);
        end
        for (int b = 0; b < beats; b++) begin
            m = '0; r = '0;
            for (int l = 0; l < LANES; l++) begin
                if (mode == 0 && l == 0) m[31:0] = w[b];
                if (mode == 1) m[l*32 +: 32] = w[b];
                if (mode == 2) m[l*32 +: 32] = w[b*LANES + l];
                r[l*32 +: 32] = $urandom() & wmask();
                if (mode == 1) r[l*32 +: 32] = r[31:0];
            end
            if (mode == 1 && bad_lane > 0 && b == 0) r[bad_lane*32] = ~r[bad_lane*32];
            mosi_q.push_back(m);
            miso_q.push_back(r);
            if (mode == 2) for (int l = 0; l < LANES; l++) rx_q.push_back(r[l*32 +: 32]);
            else rx_q.push_back(r[31:0]);
        end
        rx_en = !hold;
        issue(mode, wc, cnt, err);
        chk(err == 1'b0, "R1", "valid command flagged", err, 0);
        if (hold) begin
            bit moved;
            moved = 1'b0;
            repeat (600) @(negedge clk);
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (spi_sclk || spi_cs_n) moved = 1'b1;
            end
            chk(!moved, "R9", "bus active while rx fifo full", moved, 0);
            chk(rx_valid == 1'b1, "R9", "rx fifo holds data", rx_valid, 1);
            rx_en = 1'b1;
        end
        while (!(mosi_q.size() == 0 && rx_q.size() == 0 && spi_cs_n && cmd_ready))
            @(negedge clk);
        chk(mirror_mismatch == (mode == 1 && bad_lane > 0), "R7", "mismatch flag",
            mirror_mismatch, (mode == 1 && bad_lane > 0));
    endtask

    task automatic bad_cmd(input int mode, input int wc, input int cnt);
        logic err;
        bit moved;
        issue(mode, wc, cnt, err);
        chk(err == 1'b1, "R2", "reject pulse", err, 1);
        @(negedge clk);
        chk(cmd_err == 1'b0, "R2", "pulse lasts one cycle", cmd_err, 0);
        moved = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (!spi_cs_n || spi_sclk || !cmd_ready) moved = 1'b1;
        end
        chk(!moved, "R2", "bus quiet after reject", moved, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0, "R4", "reset bus idle", {spi_cs_n, spi_sclk}, 2'b10);
        chk(cmd_ready == 1'b1 && cmd_err == 1'b0, "R1", "reset handshake", {cmd_ready, cmd_err}, 2'b10);
        chk(rx_valid == 1'b0 && mirror_mismatch == 1'b0, "R7", "reset flags",
            {rx_valid, mirror_mismatch}, 0);
        run_cmd(0, 0, 3, 0, 1'b0);   // R5 byte words
        run_cmd(0, 2, 2, 0, 1'b0);   // R5 32-bit words
        run_cmd(1, 1, 3, 0, 1'b0);   // R6 agreeing lanes
        run_cmd(1, 0, 2, 2, 1'b0);   // R7 lane 2 disagrees
        run_cmd(0, 1, 2, 0, 1'b0);   // R7 flag cleared by next command
        run_cmd(2, 1, 8, 0, 1'b0);   // R8 two lane groups
        run_cmd(2, 2, 4, 0, 1'b0);   // R8 one group, 32-bit
        bad_cmd(2, 0, 6);            // R2 stripe count not a multiple
        bad_cmd(0, 0, 0);            // R2 zero count
        bad_cmd(0, 3, 2);            // R2 width code 3
        bad_cmd(3, 0, 2);            // R2 mode code 3
        run_cmd(0, 0, 12, 0, 1'b1);  // R9 receive back-pressure
        run_cmd(2, 0, 16, 0, 1'b0);  // R9 stripe with fifo refills
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run incomplete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule